// File: doc/BRIEF.md
# Single-Register I2C Control and Status Slave

This block is an I2C target that exposes one control byte and two status bytes to a bus master, for a device that has no register sub-addressing. The master writes to the fixed device address with a single data byte, which lands directly in the control register that drives the rest of the chip. When the master reads from the same address, it always gets the same two status bytes in a fixed order. Those bytes pack decoded identification bits, a validity flag and two pin input values.

The SCL and SDA inputs pass through a synchronizer and a short persistence filter. Start and stop are recognised as SDA transitions while SCL is high, and SDA is pulled low through an open-drain enable. The status inputs are captured once per read, when the address is acknowledged, so both returned bytes come from the same moment. While the synchronous reset is high, the slave takes no part in bus traffic and the control byte holds its reset value.

Top module: `i2c_ctl_slave`

## Requirements
- R1: After reset, `ctrl_byte` is 8'h30 and `sda_drive_low` is 0.
- R2: The slave acknowledges its address only when the 7-bit address is 7'h40, which is sent MSB first and followed by the R/W bit (0 = write, 1 = read). It acknowledges by driving SDA low during the ninth clock. Any other address gets no acknowledge, and the slave leaves the bus alone until the next start or stop.
- R3: In a write, the first data byte after an acknowledged address is acknowledged and copied to `ctrl_byte` (MSB first on the bus, bit 7 = first bit). `ctrl_byte` changes only at that point.
- R4: Any data byte after the first in a write gets no acknowledge and leaves `ctrl_byte` unchanged.
- R5: The first read byte, bit 7 down to bit 0, is: ID5, ID4, ID3, ID1, ID2, `id_valid`, `pin_a_in`, `pin_b_in`, where IDk is `id_bits[k-1]`.
- R6: The second read byte, bit 7 down to bit 0, is ID13 down to ID6, that is `id_bits[12:5]`.
- R7: Both read bytes come from status inputs sampled when the read address is acknowledged. Later changes to the inputs do not affect the current transfer.
- R8: If the master does not acknowledge a read byte, the slave stops driving SDA until the next start or stop. The slave also stops after the second read byte whatever the master answers.
- R9: While `rst` is high, bus traffic gets no acknowledge and does not change `ctrl_byte`.
- R10: Pulses on SCL shorter than HOLD_CYC clock cycles are ignored and do not count as bus clocks.
- R11: Transfers work with SCL periods of both 100 kbit/s and 400 kbit/s at a 50 MHz system clock.
- R12: A repeated start at any point in a transfer restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; bus ignored while high |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| ctrl_byte | output | 8 | Stored control byte |
| id_bits | input | 13 | Decoded identification bits, index k-1 holds IDk |
| id_valid | input | 1 | Identification valid flag |
| pin_a_in | input | 1 | Input value of general pin A |
| pin_b_in | input | 1 | Input value of general pin B |

## Verification
The bench targets the bit reorder in the first status byte. A design that packed ID1 and ID2 in natural order would return a byte whose bits 4 and 3 are exchanged. It changes the status inputs right after the address acknowledge, where a design that sampled per byte would hand back a second byte from the new values. It sends a surplus write byte and a master NACK after the first read byte, and a design that kept writing or kept driving would overwrite the control byte or pull SDA low while the master clocks on. It also sends a short SCL glitch mid-byte, a repeated start inside a data byte and traffic under reset, which catch a missing filter (the bit count shifts and the ACK disappears), a stuck data phase, and a slave that responds during reset.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam logic [6:0] DEV_ADDR = 7'h40;
    localparam logic [7:0] CTRL_RST = 8'h30;
    localparam int         ID_W     = 13;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_WR_DATA,
        PH_WR_ACK,
        PH_RD_DATA,
        PH_RD_ACK,
        PH_IGNORE
    } phase_t;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            valid;
        logic            pin_a;
        logic            pin_b;
    } status_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // First byte in [15:8], second byte in [7:0]; ID1/ID2 sit swapped.
    function automatic logic [15:0] pack_status(status_t s);
        return {s.id[4], s.id[3], s.id[2], s.id[0], s.id[1],
                s.valid, s.pin_a, s.pin_b, s.id[12:5]};
    endfunction

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_out
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_cnt;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '1;
            run_cnt  <= '0;
            line_out <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            if (synced == line_out) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(HOLD_CYC - 1)) begin
                line_out <= synced;
                run_cnt  <= '0;
            end else begin
                run_cnt <= run_cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        ev.scl_rise = scl_f & ~scl_p;
        ev.scl_fall = ~scl_f & scl_p;
        ev.start    = scl_f & scl_p & sda_p & ~sda_f;
        ev.stop     = scl_f & scl_p & ~sda_p & sda_f;
    end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic       sda_f,
    input  status_t    st_in,
    output logic       drive_low,
    output logic [7:0] ctrl,
    output phase_t     phase
);
    logic [3:0]  bit_cnt;
    logic [7:0]  rx_sh;
    logic [7:0]  tx_sh;
    logic [15:0] snap;
    logic        rw;
    logic        second;
    logic        m_nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            drive_low <= 1'b0;
            ctrl      <= CTRL_RST;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            snap      <= '0;
            rw        <= 1'b0;
            second    <= 1'b0;
            m_nack    <= 1'b0;
        end else if (ev.start) begin
            phase     <= PH_ADDR;
            bit_cnt   <= '0;
            drive_low <= 1'b0;
        end else if (ev.stop) begin
            phase     <= PH_IDLE;
            drive_low <= 1'b0;
        end else begin
            unique case (phase)
                PH_ADDR, PH_WR_DATA: begin
                    if (ev.scl_rise) begin
                        rx_sh   <= {rx_sh[6:0], sda_f};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (ev.scl_fall && bit_cnt == 4'd8) begin
                        if (phase == PH_WR_DATA) begin
                            ctrl      <= rx_sh;
                            drive_low <= 1'b1;
                            phase     <= PH_WR_ACK;
                        end else if (rx_sh[7:1] == DEV_ADDR) begin
                            drive_low <= 1'b1;
                            rw        <= rx_sh[0];
                            phase     <= PH_ADDR_ACK;
                            if (rx_sh[0]) snap <= pack_status(st_in);
                        end else begin
                            phase <= PH_IGNORE;
                        end
                    end
                end
                PH_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        bit_cnt <= '0;
                        if (rw) begin
                            tx_sh     <= snap[15:8];
                            drive_low <= ~snap[15];
                            second    <= 1'b0;
                            phase     <= PH_RD_DATA;
                        end else begin
                            drive_low <= 1'b0;
                            phase     <= PH_WR_DATA;
                        end
                    end
                end
                PH_WR_ACK: begin
                    if (ev.scl_fall) begin
                        drive_low <= 1'b0;
                        phase     <= PH_IGNORE;
                    end
                end
                PH_RD_DATA: begin
                    if (ev.scl_rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (ev.scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            drive_low <= 1'b0;
                            phase     <= PH_RD_ACK;
                        end else begin
                            tx_sh     <= {tx_sh[6:0], 1'b0};
                            drive_low <= ~tx_sh[6];
                        end
                    end
                end
                PH_RD_ACK: begin
                    if (ev.scl_rise) begin
                        m_nack <= sda_f;
                    end else if (ev.scl_fall) begin
                        if (m_nack || second) begin
                            drive_low <= 1'b0;
                            phase     <= PH_IGNORE;
                        end else begin
                            tx_sh     <= snap[7:0];
                            drive_low <= ~snap[7];
                            second    <= 1'b1;
                            bit_cnt   <= '0;
                            phase     <= PH_RD_DATA;
                        end
                    end
                end
                default: begin
                    drive_low <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_ctl_slave.sv
module i2c_ctl_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_drive_low,
    output logic [7:0]      ctrl_byte,
    input  logic [ID_W-1:0] id_bits,
    input  logic            id_valid,
    input  logic            pin_a_in,
    input  logic            pin_b_in
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] filt_lines;
    logic              scl_filt;
    logic              sda_filt;
    bus_ev_t           ev;
    status_t           st;
    phase_t            phase_w;

    assign raw_lines = {scl_i, sda_i};
    assign scl_filt  = filt_lines[1];
    assign sda_filt  = filt_lines[0];

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2cs_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .HOLD_CYC   (HOLD_CYC)
        ) u_filt (
            .clk     (clk),
            .rst     (rst),
            .line_in (raw_lines[g]),
            .line_out(filt_lines[g])
        );
    end

    i2cs_bus_events u_ev (
        .clk  (clk),
        .rst  (rst),
        .scl_f(scl_filt),
        .sda_f(sda_filt),
        .ev   (ev)
    );

    assign st = '{id: id_bits, valid: id_valid, pin_a: pin_a_in, pin_b: pin_b_in};

    i2cs_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .sda_f    (sda_filt),
        .st_in    (st),
        .drive_low(sda_drive_low),
        .ctrl     (ctrl_byte),
        .phase    (phase_w)
    );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
    import i2cs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_f,
    input logic       start_ev,
    input logic       drive,
    input logic [7:0] ctrl,
    input phase_t     phase
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!drive && ctrl == CTRL_RST));                               // R1

    AST_DRIVE_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(drive) |-> !scl_f);                                        // R2

    AST_CTRL_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl) |-> drive);                                          // R3

    AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE || phase == PH_IGNORE || phase == PH_ADDR) |-> !drive); // R8

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> phase == PH_ADDR);                                     // R12
endmodule

bind i2c_ctl_slave i2cs_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (scl_filt),
    .start_ev(ev.start),
    .drive   (sda_drive_low),
    .ctrl    (ctrl_byte),
    .phase   (phase_w)
);

// File: tb/sim_i2c_ctl_slave.sv
module sim_i2c_ctl_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        drv;
    logic [7:0]  ctrl;
    logic [12:0] id_bits = '0;
    logic        id_valid = 1'b0;
    logic        pin_a = 1'b0;
    logic        pin_b = 1'b0;
    wire         sda_bus = sda_m & ~drv;

    int  n_chk = 0;
    int  n_bad = 0;
    int  qtr   = 31;
    bit  watch = 1'b0;
    bit  seen  = 1'b0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    i2c_ctl_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_drive_low(drv), .ctrl_byte(ctrl), .id_bits(id_bits),
        .id_valid(id_valid), .pin_a_in(pin_a), .pin_b_in(pin_b)
    );

    always @(posedge clk) if (watch && drv) seen <= 1'b1;

    // {addr[6:0], wdata[7:0], expect_ack, expect_ctrl[7:0]}
    localparam logic [23:0] VEC [7] = '{
        {7'h40, 8'hA5, 1'b1, 8'hA5},
        {7'h41, 8'h3C, 1'b0, 8'hA5},
        {7'h40, 8'h00, 1'b1, 8'h00},
        {7'h20, 8'hFF, 1'b0, 8'h00},
        {7'h40, 8'hFF, 1'b1, 8'hFF},
        {7'h00, 8'h12, 1'b0, 8'hFF},
        {7'h40, 8'h5A, 1'b1, 8'h5A}
    };

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_bit(input logic b, input bit glitch, output logic r);
        sda_m = b;
        if (glitch) begin
            wq(qtr / 2);
            scl_m = 1'b1; wq(2); scl_m = 1'b0;
            wq(qtr - qtr / 2);
        end else begin
            wq(qtr);
        end
        scl_m = 1'b1; wq(qtr);
        r = sda_bus;  wq(qtr);
        scl_m = 1'b0; wq(qtr);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(qtr);
        scl_m = 1'b1; wq(qtr);
        sda_m = 1'b0; wq(qtr);
        scl_m = 1'b0; wq(qtr);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(qtr);
        scl_m = 1'b1; wq(qtr);
        sda_m = 1'b1; wq(qtr);
    endtask

    task automatic wr_byte(input logic [7:0] v, input bit glitch, output bit ack);
        logic r;
        for (int i = 0; i < 8; i++) bus_bit(v[7-i], glitch && i == 3, r);
        bus_bit(1'b1, 1'b0, r);
        ack = !r;
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] d);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, 1'b0, r);
            d = {d[6:0], r};
        end
        bus_bit(!give_ack, 1'b0, r);
    endtask

    function automatic logic [7:0] exp_b1(logic [12:0] id, logic v, logic a, logic b);
        return {id[4], id[3], id[2], id[0], id[1], v, a, b};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        finish_run();
    end

    initial begin
        bit         ack;
        logic [7:0] d1, d2;
        logic [12:0] id_old;
        wq(5);
        rst = 1'b0;
        wq(5);
        chk(ctrl == 8'h30, "R1 ctrl reset", ctrl, 8'h30);
        chk(drv == 1'b0, "R1 sda released", drv, 0);

        // Table walk, alternating 400k and 100k timing (R2 R3 R11)
        for (int i = 0; i < 7; i++) begin
            qtr = (i % 2 == 0) ? 31 : 125;
            bus_start();
            wr_byte({VEC[i][23:17], 1'b0}, 1'b0, ack);
            if (ack) wr_byte(VEC[i][16:9], 1'b0, ack);
            bus_stop();
            wq(10);
            chk(ack == VEC[i][8], "R2 R11 address ack", ack, VEC[i][8]);
            chk(ctrl == VEC[i][7:0], "R3 R11 ctrl value", ctrl, VEC[i][7:0]);
        end
        qtr = 31;

        // Read layout (R5 R6)
        id_bits = 13'b1_0110_1001_0110; id_valid = 1'b1; pin_a = 1'b0; pin_b = 1'b1;
        bus_start();
        wr_byte({7'h40, 1'b1}, 1'b0, ack);
        rd_byte(1'b1, d1);
        rd_byte(1'b0, d2);
        bus_stop();
        chk(d1 == exp_b1(id_bits, id_valid, pin_a, pin_b), "R5 first status byte",
            d1, exp_b1(id_bits, id_valid, pin_a, pin_b));
        chk(d2 == id_bits[12:5], "R6 second status byte", d2, id_bits[12:5]);

        // Snapshot at address ack (R7)
        id_bits = 13'b0_1001_0110_1001; id_valid = 1'b0; pin_a = 1'b1; pin_b = 1'b0;
        id_old = id_bits;
        bus_start();
        wr_byte({7'h40, 1'b1}, 1'b0, ack);
        id_bits = ~id_bits; id_valid = 1'b1; pin_a = 1'b0; pin_b = 1'b1;
        rd_byte(1'b1, d1);
        rd_byte(1'b0, d2);
        bus_stop();
        chk(d1 == exp_b1(id_old, 1'b0, 1'b1, 1'b0), "R7 snapshot byte 1",
            d1, exp_b1(id_old, 1'b0, 1'b1, 1'b0));
        chk(d2 == id_old[12:5], "R7 snapshot byte 2", d2, id_old[12:5]);

        // Master NACK releases SDA (R8)
        id_bits = 13'h0000; id_valid = 1'b0; pin_a = 1'b0; pin_b = 1'b0;
        bus_start();
        wr_byte({7'h40, 1'b1}, 1'b0, ack);
        rd_byte(1'b0, d1);
        watch = 1'b1;
        rd_byte(1'b0, d2);
        watch = 1'b0;
        bus_stop();
        chk(d1 == 8'h00, "R8 first byte before nack", d1, 0);
        chk(!seen && d2 == 8'hFF, "R8 sda released after nack", d2, 8'hFF);

        // Surplus write byte (R4)
        bus_start();
        wr_byte({7'h40, 1'b0}, 1'b0, ack);
        wr_byte(8'h11, 1'b0, ack);
        chk(ack, "R4 first data byte ack", ack, 1);
        wr_byte(8'h22, 1'b0, ack);
        bus_stop();
        wq(10);
        chk(!ack, "R4 surplus byte nack", ack, 0);
        chk(ctrl == 8'h11, "R4 ctrl holds first byte", ctrl, 8'h11);

        // Traffic under reset (R9)
        rst = 1'b1;
        bus_start();
        wr_byte({7'h40, 1'b0}, 1'b0, ack);
        wr_byte(8'h77, 1'b0, d1[0]);
        bus_stop();
        chk(!ack, "R9 no ack in reset", ack, 0);
        rst = 1'b0;
        wq(10);
        chk(ctrl == 8'h30, "R9 ctrl untouched", ctrl, 8'h30);

        // SCL glitch rejection (R10)
        bus_start();
        wr_byte({7'h40, 1'b0}, 1'b1, ack);
        chk(ack, "R10 ack despite glitch", ack, 1);
        wr_byte(8'hC3, 1'b1, ack);
        bus_stop();
        wq(10);
        chk(ctrl == 8'hC3, "R10 data despite glitch", ctrl, 8'hC3);

        // Repeated start inside a data byte (R12)
        bus_start();
        wr_byte({7'h40, 1'b0}, 1'b0, ack);
        for (int i = 0; i < 3; i++) bus_bit(1'b0, 1'b0, d1[0]);
        bus_start();
        wr_byte({7'h40, 1'b0}, 1'b0, ack);
        chk(ack, "R12 ack after repeated start", ack, 1);
        wr_byte(8'h66, 1'b0, ack);
        bus_stop();
        wq(10);
        chk(ctrl == 8'h66, "R12 ctrl after repeated start", ctrl, 8'h66);

        finish_run();
    end
endmodule